// File: doc/BRIEF.md
# Power-On Clock Gating Controller

This controller decides when the chip's digital clocks and their clock receivers are on, so that they draw power only while there is work to do. Two sources ask for power. The acquisition controller holds a level request through the acquisition and conversion phases. The readout chain sends a start pulse when it is this chip's turn to read out. The internal power request is the OR of these two held requests and of a force input.

Each held request turns on asynchronously, so a clock comes up without waiting for an edge of a clock that may not be running. It turns off synchronously on a free-running sampling clock, with a fixed two-edge latency after the release strobe. For each gated clock domain, the request drives a receiver enable and a clock enable. The clock enable is captured in a gate that is transparent only while that domain's clock is low, so the gated clock never shows a shortened high pulse.

The start pulse also starts the readout state machine. It does this through a synchronizer and a low-pass filter that rejects short glitches. A mode input can bypass the filter and pass through the edge of the raw synchronized start instead.

Top module: `pod_ctrl`

## Requirements
- R1: While reset is held with all requests low, `rx_en`, `clk_en`, `gclk` and `ro_start_pulse` are all 0.
- R2: When `daq_pwr` rises, every bit of `rx_en` goes to 1 in the same time step, with no sampling-clock edge needed.
- R3: If `conv_done` is high at a sampling-clock edge while `daq_pwr` is low, the acquisition request drops after the second such edge (counting that one), and not earlier.
- R4: A `conv_done` strobe that arrives while `daq_pwr` is still high is ignored, so the power stays on after `daq_pwr` later falls.
- R5: A rise of `start_ro` sets every bit of `rx_en` at once. An `end_ro` strobe releases the readout request after the second sampling edge, counting the edge at which it is seen.
- R6: In filtered mode (`raw_mode`=0), exactly one `ro_start_pulse` occurs, one cycle long. It is high after the 6th sampling edge following the rise of `start_ro`: two synchronizer stages plus four consecutive high samples.
- R7: In filtered mode, a `start_ro` that is high for fewer than four sampling edges produces no `ro_start_pulse`.
- R8: In raw mode (`raw_mode`=1), any `start_ro` high for at least one sampling edge produces exactly one pulse, high after the 3rd edge.
- R9: While `force_on` is 1, all bits of `rx_en` are 1, and all bits of `clk_en` are 1 once each domain has passed a low phase.
- R10: A `clk_en` bit changes only while its domain clock is low. An enabled `gclk` follows its clock edge for edge with full-width high pulses. A disabled `gclk` stays at 0.
- R11: The power request is the OR of its sources: releasing the acquisition request while the readout request is held leaves `rx_en` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Free-running sampling clock for synchronization, release and filtering |
| rst_n | input | 1 | Asynchronous active-low reset |
| dom_clk | input | NUM_DOM | Raw clocks of the gated domains |
| daq_pwr | input | 1 | Acquisition power request level |
| conv_done | input | 1 | End-of-conversion strobe; releases the acquisition request |
| start_ro | input | 1 | Raw readout start from the previous chip |
| end_ro | input | 1 | End-of-readout strobe; releases the readout request |
| force_on | input | 1 | Holds power and clocks on while high |
| raw_mode | input | 1 | 1 bypasses the start filter |
| rx_en | output | NUM_DOM | Clock receiver enable, one per domain |
| clk_en | output | NUM_DOM | Latched clock enable, one per domain |
| gclk | output | NUM_DOM | Gated clock, one per domain |
| ro_start_pulse | output | 1 | One-cycle internal readout start on clk_slow |

## Verification
The hardest case to reach is the filter boundary. A start that is one sample short of the filter length must be rejected, and one that exactly meets it must give a single pulse on a fixed edge. The bench sweeps the start width from one to six sampling cycles in both modes. It records at which edge the first pulse appears and how many appear. It then releases the readout request between runs so that each run starts from idle. Glitch-free gating is checked by timing the width of every gated high pulse on two domains with unrelated periods.

// File: rtl/pod_pkg.sv
package pod_pkg;

   // Sources that can hold the digital power on
   typedef struct packed {
      logic daq;   // acquisition controller request
      logic ro;    // readout chain request
      logic frc;   // force input
   } pod_req_t;

   function automatic logic pod_any(input pod_req_t r);
      return r.daq | r.ro | r.frc;
   endfunction

   localparam int unsigned POD_WINDOW_MAX = 4; // longest filter built as a shift window

endpackage

// File: rtl/pod_rel_hold.sv
// Request hold: asynchronous set, synchronous release through a short chain.
module pod_rel_hold #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_a,
   input  logic rel,
   output logic hold
);

   if (STAGES < 1) begin : g_bad_stages
      $error("pod_rel_hold: STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n or posedge set_a) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else if (set_a) begin
         chain_q <= '1;
      end else begin
         for (int i = STAGES - 1; i > 0; i--) begin
            chain_q[i] <= chain_q[i-1];
         end
         chain_q[0] <= chain_q[0] & ~rel;
      end
   end

   assign hold = chain_q[STAGES-1];

endmodule

// File: rtl/pod_start_filter.sv
// Start synchronizer, low-pass filter and internal start pulse.
module pod_start_filter #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_LEN    = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_raw,
   input  logic raw_mode,
   output logic pulse
);
   import pod_pkg::*;

   localparam int unsigned CNT_W = $clog2(FILT_LEN + 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pod_start_filter: SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 2) begin : g_bad_filt
      $error("pod_start_filter: FILT_LEN must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   samp;
   logic                   samp_d;
   logic                   raw_pulse_q;
   logic                   filt_pulse_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         samp_d <= 1'b0;
         raw_pulse_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], start_raw};
         samp_d <= samp;
         raw_pulse_q <= samp & ~samp_d;
      end
   end

   assign samp = sync_q[SYNC_STAGES-1];

   if (FILT_LEN <= POD_WINDOW_MAX) begin : g_window
      // Short filter: shift window of the last FILT_LEN samples
      logic [FILT_LEN-1:0] win_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            win_q <= '0;
            filt_pulse_q <= 1'b0;
         end else begin
            win_q <= {win_q[FILT_LEN-2:0], samp};
            filt_pulse_q <= samp & (&win_q[FILT_LEN-2:0]) & ~win_q[FILT_LEN-1];
         end
      end
   end else begin : g_counter
      // Long filter: saturating run-length counter
      logic [CNT_W-1:0] run_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            run_q <= '0;
            filt_pulse_q <= 1'b0;
         end else if (!samp) begin
            run_q <= '0;
            filt_pulse_q <= 1'b0;
         end else begin
            if (run_q != CNT_W'(FILT_LEN)) begin
               run_q <= run_q + 1'b1;
            end
            filt_pulse_q <= (run_q == CNT_W'(FILT_LEN - 1));
         end
      end
   end

   assign pulse = raw_mode ? raw_pulse_q : filt_pulse_q;

endmodule

// File: rtl/pod_clk_gate.sv
// Clock gate: enable captured only while the clock is low.
module pod_clk_gate (
   input  logic clk,
   input  logic en_req,
   output logic en_q,
   output logic gclk
);

   always_latch begin
      if (!clk) begin
         en_q = en_req;
      end
   end

   assign gclk = clk & en_q;

endmodule

// File: rtl/pod_ctrl.sv
module pod_ctrl #(
   parameter int unsigned NUM_DOM     = 2,
   parameter int unsigned REL_STAGES  = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_LEN    = 4
) (
   input  logic               clk_slow,
   input  logic               rst_n,
   input  logic [NUM_DOM-1:0] dom_clk,
   input  logic               daq_pwr,
   input  logic               conv_done,
   input  logic               start_ro,
   input  logic               end_ro,
   input  logic               force_on,
   input  logic               raw_mode,
   output logic [NUM_DOM-1:0] rx_en,
   output logic [NUM_DOM-1:0] clk_en,
   output logic [NUM_DOM-1:0] gclk,
   output logic               ro_start_pulse
);
   import pod_pkg::*;

   if (NUM_DOM < 1) begin : g_bad_dom
      $error("pod_ctrl: NUM_DOM must be at least 1");
   end

   pod_req_t req;
   logic     pwr_req;

   pod_rel_hold #(.STAGES(REL_STAGES)) u_daq_hold (
      .clk   (clk_slow),
      .rst_n (rst_n),
      .set_a (daq_pwr),
      .rel   (conv_done),
      .hold  (req.daq)
   );

   pod_rel_hold #(.STAGES(REL_STAGES)) u_ro_hold (
      .clk   (clk_slow),
      .rst_n (rst_n),
      .set_a (start_ro),
      .rel   (end_ro),
      .hold  (req.ro)
   );

   assign req.frc = force_on;
   assign pwr_req = pod_any(req);

   pod_start_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .FILT_LEN    (FILT_LEN)
   ) u_filter (
      .clk       (clk_slow),
      .rst_n     (rst_n),
      .start_raw (start_ro),
      .raw_mode  (raw_mode),
      .pulse     (ro_start_pulse)
   );

   for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      assign rx_en[d] = pwr_req;
      pod_clk_gate u_gate (
         .clk    (dom_clk[d]),
         .en_req (pwr_req),
         .en_q   (clk_en[d]),
         .gclk   (gclk[d])
      );
   end

endmodule

// File: rtl/pod_ctrl_chk.sv
module pod_ctrl_chk #(
   parameter int unsigned NUM_DOM = 2
) (
   input logic               clk_slow,
   input logic               rst_n,
   input logic [NUM_DOM-1:0] dom_clk,
   input logic               daq_pwr,
   input logic               conv_done,
   input logic               start_ro,
   input logic               end_ro,
   input logic               force_on,
   input logic [NUM_DOM-1:0] rx_en,
   input logic [NUM_DOM-1:0] clk_en,
   input logic               ro_start_pulse
);

   // R2: an acquisition request always shows on the receiver enables
   p_daq_on_r2: assert property (@(posedge clk_slow) disable iff (!rst_n)
      daq_pwr |-> (&rx_en));

   // R9: force keeps the receivers on
   p_force_on_r9: assert property (@(posedge clk_slow) disable iff (!rst_n)
      force_on |-> (&rx_en));

   // R3: both holds released together drop power within two edges
   p_release_bound_r3: assert property (@(posedge clk_slow) disable iff (!rst_n)
      (conv_done && end_ro && !daq_pwr && !start_ro && !force_on)
      ##1 (!daq_pwr && !start_ro && !force_on) |=> !(|rx_en));

   // R6: the internal start is a single-cycle pulse
   p_pulse_single_r6: assert property (@(posedge clk_slow) disable iff (!rst_n)
      ro_start_pulse |=> !ro_start_pulse);

   // R10: a clock enable moves only during the low phase of its clock
   for (genvar d = 0; d < NUM_DOM; d++) begin : g_gate_chk
      always @(clk_en[d]) begin
         if (rst_n) begin
            p_gate_low_r10: assert (!dom_clk[d]);
         end
      end
   end

endmodule

bind pod_ctrl pod_ctrl_chk #(.NUM_DOM(NUM_DOM)) u_chk (
   .clk_slow       (clk_slow),
   .rst_n          (rst_n),
   .dom_clk        (dom_clk),
   .daq_pwr        (daq_pwr),
   .conv_done      (conv_done),
   .start_ro       (start_ro),
   .end_ro         (end_ro),
   .force_on       (force_on),
   .rx_en          (rx_en),
   .clk_en         (clk_en),
   .ro_start_pulse (ro_start_pulse)
);

// File: tb/tb_pod_ctrl.sv
`timescale 1ns/1ps
module tb_pod_ctrl;

   localparam int ND = 2;
   localparam int FL = 4;
   localparam int ALL = (1 << ND) - 1;

   logic          clk_slow = 1'b0;
   logic          rst_n = 1'b0;
   logic [ND-1:0] dom_clk = '0;
   logic daq_pwr = 0, conv_done = 0, start_ro = 0, end_ro = 0;
   logic force_on = 0, raw_mode = 0;
   logic [ND-1:0] rx_en, clk_en, gclk;
   logic          ro_start_pulse;

   int n_chk = 0, n_fail = 0;
   int g0 = 0, g1 = 0, d0 = 0, d1 = 0, wbad = 0;
   realtime t0 = 0.0, t1 = 0.0;

   always #10 clk_slow = ~clk_slow;   // 50 MHz
   always #5  dom_clk[0] = ~dom_clk[0];
   always #7  dom_clk[1] = ~dom_clk[1];

   pod_ctrl #(.NUM_DOM(ND), .FILT_LEN(FL)) dut (
      .clk_slow(clk_slow), .rst_n(rst_n), .dom_clk(dom_clk),
      .daq_pwr(daq_pwr), .conv_done(conv_done), .start_ro(start_ro),
      .end_ro(end_ro), .force_on(force_on), .raw_mode(raw_mode),
      .rx_en(rx_en), .clk_en(clk_en), .gclk(gclk),
      .ro_start_pulse(ro_start_pulse)
   );

   // gated clock edge counts and high-pulse widths (R10)
   always @(posedge gclk[0]) begin g0++; t0 = $realtime; end
   always @(posedge gclk[1]) begin g1++; t1 = $realtime; end
   always @(posedge dom_clk[0]) d0++;
   always @(posedge dom_clk[1]) d1++;
   always @(negedge gclk[0]) if ($realtime - t0 < 4.99 || $realtime - t0 > 5.01) wbad++;
   always @(negedge gclk[1]) if ($realtime - t1 < 6.99 || $realtime - t1 > 7.01) wbad++;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk_slow);
      @(negedge clk_slow);
   endtask

   // which: 0 = conv_done, 1 = end_ro; strobe for one sampling edge
   task automatic release_chk(input int which, input string tag, input bit expect_off);
      if (which == 0) conv_done = 1; else end_ro = 1;
      edges(1);
      conv_done = 0; end_ro = 0;
      chk(rx_en == ALL, {tag, " still on after first edge"}, rx_en, ALL);
      edges(1);
      chk(rx_en == (expect_off ? 0 : ALL), {tag, " after second edge"}, rx_en,
          expect_off ? 0 : ALL);
   endtask

   task automatic run();
      edges(3);
      chk(rx_en == 0 && clk_en == 0, "R1 enables in reset", {rx_en, clk_en}, 0);
      chk(gclk == 0 && ro_start_pulse == 0, "R1 gclk/pulse in reset", {gclk, ro_start_pulse}, 0);
      rst_n = 1;
      edges(2);

      // R2 asynchronous set
      daq_pwr = 1; #1;
      chk(rx_en == ALL, "R2 async power on", rx_en, ALL);
      edges(1);

      // R4 strobe ignored while request still high
      conv_done = 1; edges(1); conv_done = 0; daq_pwr = 0;
      edges(3);
      chk(rx_en == ALL, "R4 early conv_done ignored", rx_en, ALL);

      // R10 gate open: gated edges track the clock
      g0 = 0; g1 = 0; d0 = 0; d1 = 0;
      edges(10);
      chk(g0 == d0 && g0 > 0, "R10 dom0 edges when enabled", g0, d0);
      chk(g1 == d1 && g1 > 0, "R10 dom1 edges when enabled", g1, d1);
      chk(clk_en == ALL, "R10 clk_en open", clk_en, ALL);

      // R3 bounded synchronous release
      release_chk(0, "R3", 1);
      edges(2);
      chk(clk_en == 0, "R10 clk_en closed", clk_en, 0);
      g0 = 0; g1 = 0;
      edges(10);
      chk(g0 == 0 && g1 == 0, "R10 no gated edges when disabled", g0 + g1, 0);

      // R11 OR of sources
      daq_pwr = 1; start_ro = 1; edges(1);
      start_ro = 0; daq_pwr = 0;
      edges(FL + 4);
      release_chk(0, "R11", 0);
      release_chk(1, "R5", 1);

      // R6 R7 R8 sweep of start width in both modes
      for (int m = 0; m < 2; m++) begin
         raw_mode = m[0];
         for (int len = 1; len <= 6; len++) begin
            int cnt = 0;
            int first = 0;
            int exp_cnt = (m == 1) ? 1 : ((len >= FL) ? 1 : 0);
            int exp_first = (m == 1) ? 3 : 2 + FL;
            start_ro = 1; #1;
            chk(rx_en == ALL, "R5 start sets power async", rx_en, ALL);
            for (int i = 1; i <= 12; i++) begin
               @(posedge clk_slow); @(negedge clk_slow);
               if (ro_start_pulse) begin
                  cnt++;
                  if (first == 0) first = i;
               end
               if (i == len) start_ro = 0;
            end
            chk(cnt == exp_cnt, (m == 1) ? "R8 pulse count raw" :
                ((len >= FL) ? "R6 pulse count filtered" : "R7 short start rejected"),
                cnt, exp_cnt);
            if (exp_cnt != 0)
               chk(first == exp_first, (m == 1) ? "R8 pulse edge" : "R6 pulse edge",
                   first, exp_first);
            release_chk(1, "R5", 1);
         end
      end
      raw_mode = 0;

      // R9 force
      force_on = 1; #1;
      chk(rx_en == ALL, "R9 force rx_en", rx_en, ALL);
      edges(2);
      chk(clk_en == ALL, "R9 force clk_en", clk_en, ALL);
      force_on = 0;
      edges(2);
      chk(rx_en == 0 && clk_en == 0, "R9 force removed", {rx_en, clk_en}, 0);

      chk(wbad == 0, "R10 full-width gated pulses", wbad, 0);
   endtask

   initial begin
      fork
         run();
         begin
            #200_000;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule